// File: doc/BRIEF.md
# AU-4 Pointer Interpreter

This block follows the two pointer bytes and the three justification-opportunity bytes that precede each higher-order payload container. It decides where the container starts inside the frame. The first pointer byte is latched on its strobe. When the second byte arrives, the 16-bit word is decoded in the same cycle and classified as one of five kinds: a new-data pointer, a normal pointer, an increment, a decrement, or a concatenation word. Anything else is invalid. The active offset, its validity and the event flags are updated at that clock edge.

Downstream payload logic uses two byte-slot flags from this block. The first marks the three opportunity bytes that carry payload in a decrement frame. The second marks the three byte slots right after them, which are stuffing in an increment frame. The offset counts 3-byte units, from 0 to 782, starting at the first byte after the last opportunity byte. Repeated faults or a stream of new-data pointers raise loss of pointer.

Top module: `ptr_tracker`

## Requirements
- R1: The pointer word is {first byte, second byte}, with bit 15 as the most significant bit. Bits 15:12 are the new-data field, bits 11:10 are the size field (must be 2'b10), and bits 9:0 are the offset. The increment votes sit at bits 9,7,5,3,1 and the decrement votes at bits 8,6,4,2,0. Inverting only two vote bits is not a justification.
- R2: When at least 3 of the 4 new-data bits match 4'b1001, the size field is 2'b10 and the offset is at most 782, the offset is loaded at once. `offsetValid` goes high and `ndfPulse` is high for one cycle.
- R3: A normal pointer has at least 3 of its 4 new-data bits matching 4'b0110. Three consecutive normal pointers that carry the same in-range offset and are not justifications make that offset active, with `offsetValid` high.
- R4: With a valid offset, a normal-code word in which at least 3 of the 5 increment bits differ from the active offset, and fewer than 3 decrement bits differ, adds 1 to the offset (782 wraps to 0). `incPulse` is high for one cycle.
- R5: The mirror case, with at least 3 of 5 decrement bits inverted and fewer than 3 increment bits inverted, subtracts 1 from the offset (0 wraps to 782). `decPulse` is high for one cycle.
- R6: After an increment or decrement, the next 3 pointer words are never taken as a justification.
- R7: Eight consecutive invalid words raise `lopOut` and drop `offsetValid`. A word is invalid if it has neither new-data code, has a size field other than 2'b10, or has an out-of-range value outside a justification. Acceptance under R3 clears `lopOut`.
- R8: Eight consecutive accepted new-data pointers raise `lopOut` and drop `offsetValid`.
- R9: A word with bits 15:12 equal to 4'b1001 and bits 9:0 all ones sets `concatInd` and leaves the offset unchanged. Any other word clears `concatInd`.
- R10: In a decrement frame, `h3Payload` is high during each of the three opportunity-byte strobes. It is never high in other frames.
- R11: In an increment frame, `stuffOut` is high on the first three `byteEn` slots after the third opportunity byte.
- R12: After reset, the offset is 0 and `offsetValid`, `lopOut`, `concatInd` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| dataIn | input | 8 | Byte stream |
| h1Strobe | input | 1 | Marks the first pointer byte; starts a frame |
| h2Strobe | input | 1 | Marks the second pointer byte; triggers decode |
| h3Strobe | input | 1 | Marks each opportunity byte |
| byteEn | input | 1 | Marks a byte slot after the opportunity bytes |
| offset | output | 10 | Active payload offset |
| offsetValid | output | 1 | Offset is established |
| incPulse | output | 1 | Increment accepted |
| decPulse | output | 1 | Decrement accepted |
| ndfPulse | output | 1 | New-data pointer accepted |
| concatInd | output | 1 | Last word was a concatenation word |
| lopOut | output | 1 | Loss of pointer |
| h3Payload | output | 1 | Opportunity byte carries payload |
| stuffOut | output | 1 | Current byte slot is stuffing |

## Verification
The offset, validity, concatenation, loss-of-pointer flag and the three pulses are all registered at the edge that captures the second pointer byte. They are visible in the next cycle, which is the first opportunity-byte cycle. The bench samples them at the falling edge that opens that cycle, and it reads each pulse only there. `h3Payload` follows the opportunity strobe in the same cycle, so it is sampled shortly after each strobe is driven. `stuffOut` starts one cycle after the third opportunity byte and is counted over the next three slots. Each vector therefore expects three, or zero, of each slot flag.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

  // Features of the current pointer word, produced by the datapath
  typedef struct packed {
    logic ndfOn;      // new-data code by 3-of-4 vote
    logic ndfOff;     // normal code by 3-of-4 vote
    logic ssOk;       // size field matches
    logic inRange;    // offset within the frame
    logic iFlip;      // majority of increment bits inverted
    logic dFlip;      // majority of decrement bits inverted
    logic concatWord; // concatenation word
    logic candMatch;  // value equals stored candidate
  } ptrFlags_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadActive;
    logic loadCand;
    logic doInc;
    logic doDec;
  } ptrCmd_t;

endpackage

// File: rtl/ptr_datapath.sv
module ptr_datapath
  import ptr_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int OFF_MAX = 782,
  parameter logic [1:0] SS_CODE = 2'b10,
  parameter logic [3:0] NDF_ON = 4'b1001,
  parameter int NDF_MIN = 3,
  parameter int H3_BYTES = 3,
  parameter int STUFF_BYTES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dataIn,
  input  logic             h1Strobe,
  input  logic             h3Strobe,
  input  logic             byteEn,
  input  ptrCmd_t          cmd,
  input  logic             posFrame,
  output ptrFlags_t        flags,
  output logic [OFF_W-1:0] offset,
  output logic             stuffOut
);
  localparam int WORD_W = OFF_W + 6;
  localparam int HI_W = WORD_W - 8;
  localparam int VOTES = OFF_W / 2;
  localparam int VOTE_MIN = VOTES / 2 + 1;
  localparam logic [3:0] NDF_OFF = ~NDF_ON;
  localparam int SEEN_W = $clog2(H3_BYTES + 1);
  localparam int STUFF_W = $clog2(STUFF_BYTES + 1);

  logic [HI_W-1:0]   h1Reg;
  logic [OFF_W-1:0]  activeReg, candReg;
  logic [WORD_W-1:0] word;
  logic [3:0]        ndfField;
  logic [1:0]        ssField;
  logic [OFF_W-1:0]  valField, diff, iMask, dMask;
  logic [SEEN_W-1:0] h3Seen;
  logic [STUFF_W-1:0] stuffLeft;
  logic              stuffWin;

  // Alternating vote masks: odd bits vote increment, even bits decrement
  for (genvar k = 0; k < OFF_W; k++) begin : g_mask
    assign iMask[k] = (k % 2) == 1;
    assign dMask[k] = (k % 2) == 0;
  end

  assign word     = {h1Reg, dataIn};
  assign ndfField = word[WORD_W-1 -: 4];
  assign ssField  = word[OFF_W+1:OFF_W];
  assign valField = word[OFF_W-1:0];
  assign diff     = valField ^ activeReg;

  always_comb begin
    flags.ndfOn      = $countones(~(ndfField ^ NDF_ON)) >= NDF_MIN;
    flags.ndfOff     = $countones(~(ndfField ^ NDF_OFF)) >= NDF_MIN;
    flags.ssOk       = ssField == SS_CODE;
    flags.inRange    = valField <= OFF_W'(OFF_MAX);
    flags.iFlip      = $countones(diff & iMask) >= VOTE_MIN;
    flags.dFlip      = $countones(diff & dMask) >= VOTE_MIN;
    flags.concatWord = (ndfField == NDF_ON) && (valField == '1);
    flags.candMatch  = valField == candReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h1Reg     <= '0;
      activeReg <= '0;
      candReg   <= '0;
    end else begin
      if (h1Strobe) h1Reg <= dataIn[HI_W-1:0];
      if (cmd.loadCand) candReg <= valField;
      if (cmd.loadActive) activeReg <= valField;
      else if (cmd.doInc)
        activeReg <= (activeReg == OFF_W'(OFF_MAX)) ? '0 : activeReg + 1'b1;
      else if (cmd.doDec)
        activeReg <= (activeReg == '0) ? OFF_W'(OFF_MAX) : activeReg - 1'b1;
    end
  end

  // Byte slots after the last opportunity byte
  assign stuffWin = byteEn && !h3Strobe && (stuffLeft != '0);
  assign stuffOut = stuffWin && posFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      h3Seen    <= '0;
      stuffLeft <= '0;
    end else if (h1Strobe) begin
      h3Seen    <= '0;
      stuffLeft <= '0;
    end else begin
      if (h3Strobe) h3Seen <= h3Seen + 1'b1;
      if (h3Strobe && h3Seen == SEEN_W'(H3_BYTES - 1))
        stuffLeft <= STUFF_W'(STUFF_BYTES);
      else if (stuffWin)
        stuffLeft <= stuffLeft - 1'b1;
    end
  end

  assign offset = activeReg;

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doInc |=> offset == (($past(offset) == OFF_W'(OFF_MAX)) ? '0 : $past(offset) + 1'b1)); // R4
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doDec |=> offset == (($past(offset) == '0) ? OFF_W'(OFF_MAX) : $past(offset) - 1'b1)); // R5

endmodule

// File: rtl/ptr_control.sv
module ptr_control
  import ptr_pkg::*;
#(
  parameter int HOLD_FRAMES = 3,
  parameter int ACCEPT_RUN = 3,
  parameter int LOP_RUN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      h1Strobe,
  input  logic      h2Strobe,
  input  ptrFlags_t flags,
  output ptrCmd_t   cmd,
  output logic      valid,
  output logic      incPulse,
  output logic      decPulse,
  output logic      ndfPulse,
  output logic      concatInd,
  output logic      lop,
  output logic      negFrame,
  output logic      posFrame
);
  localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);
  localparam int ACC_W = $clog2(ACCEPT_RUN + 1);
  localparam int RUN_W = $clog2(LOP_RUN + 1);

  logic [HOLD_W-1:0] holdCnt, holdNext;
  logic [ACC_W-1:0]  candCnt, candNext;
  logic [RUN_W-1:0]  invCnt, invNext, ndfCnt, ndfNext;
  logic validReg, lopReg, validNext, lopNext;
  logic isConcat, isNdf, normalCode, canJust, isInc, isDec, isNormal, isInvalid;
  logic freshCand, accept;

  always_comb begin
    isConcat   = flags.concatWord;
    isNdf      = !isConcat && flags.ndfOn && flags.ssOk && flags.inRange;
    normalCode = !isConcat && flags.ndfOff && flags.ssOk;
    canJust    = validReg && (holdCnt == '0);
    isInc      = normalCode && canJust && flags.iFlip && !flags.dFlip;
    isDec      = normalCode && canJust && flags.dFlip && !flags.iFlip;
    isNormal   = normalCode && !isInc && !isDec && flags.inRange;
    isInvalid  = !isConcat && !isNdf && !isInc && !isDec && !isNormal;

    freshCand = !(flags.candMatch && candCnt != '0);
    if (isNormal)
      candNext = freshCand ? ACC_W'(1)
               : ((candCnt == ACC_W'(ACCEPT_RUN)) ? candCnt : candCnt + 1'b1);
    else if (isNdf || isInc || isDec) candNext = '0;
    else candNext = candCnt;
    accept = isNormal && (candNext == ACC_W'(ACCEPT_RUN));

    if (isInvalid) invNext = (invCnt == RUN_W'(LOP_RUN)) ? invCnt : invCnt + 1'b1;
    else if (isConcat) invNext = invCnt;
    else invNext = '0;

    if (isNdf) ndfNext = (ndfCnt == RUN_W'(LOP_RUN)) ? ndfCnt : ndfCnt + 1'b1;
    else if (isConcat) ndfNext = ndfCnt;
    else ndfNext = '0;

    if (invNext == RUN_W'(LOP_RUN) || ndfNext == RUN_W'(LOP_RUN)) lopNext = 1'b1;
    else if (accept || isNdf) lopNext = 1'b0;
    else lopNext = lopReg;

    if (lopNext) validNext = 1'b0;
    else if (accept || isNdf || isInc || isDec) validNext = 1'b1;
    else validNext = validReg;

    if (isInc || isDec) holdNext = HOLD_W'(HOLD_FRAMES);
    else holdNext = (holdCnt != '0) ? holdCnt - 1'b1 : '0;

    cmd.loadActive = h2Strobe && (isNdf || accept);
    cmd.loadCand   = h2Strobe && isNormal && freshCand;
    cmd.doInc      = h2Strobe && isInc;
    cmd.doDec      = h2Strobe && isDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0; candCnt <= '0; invCnt <= '0; ndfCnt <= '0;
      validReg <= 1'b0; lopReg <= 1'b0; concatInd <= 1'b0;
      incPulse <= 1'b0; decPulse <= 1'b0; ndfPulse <= 1'b0;
      negFrame <= 1'b0; posFrame <= 1'b0;
    end else begin
      incPulse <= h2Strobe && isInc;
      decPulse <= h2Strobe && isDec;
      ndfPulse <= h2Strobe && isNdf;
      if (h2Strobe) begin
        holdCnt   <= holdNext;
        candCnt   <= candNext;
        invCnt    <= invNext;
        ndfCnt    <= ndfNext;
        validReg  <= validNext;
        lopReg    <= lopNext;
        concatInd <= isConcat;
      end
      if (h1Strobe) begin
        negFrame <= 1'b0;
        posFrame <= 1'b0;
      end else if (h2Strobe) begin
        negFrame <= isDec;
        posFrame <= isInc;
      end
    end
  end

  assign valid = validReg;
  assign lop   = lopReg;

  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (h2Strobe && holdCnt != '0) |=> !(incPulse || decPulse)); // R6
  AST_LOP_NOT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lopReg |-> !validReg); // R7
  AST_ONE_JUST: assert property (@(posedge clk) disable iff (!rstN)
    !(incPulse && decPulse)); // R4

endmodule

// File: rtl/ptr_tracker.sv
module ptr_tracker
  import ptr_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int OFF_MAX = 782,
  parameter int HOLD_FRAMES = 3,
  parameter int ACCEPT_RUN = 3,
  parameter int LOP_RUN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dataIn,
  input  logic             h1Strobe,
  input  logic             h2Strobe,
  input  logic             h3Strobe,
  input  logic             byteEn,
  output logic [OFF_W-1:0] offset,
  output logic             offsetValid,
  output logic             incPulse,
  output logic             decPulse,
  output logic             ndfPulse,
  output logic             concatInd,
  output logic             lopOut,
  output logic             h3Payload,
  output logic             stuffOut
);
  ptrFlags_t flags;
  ptrCmd_t   cmd;
  logic      negFrame, posFrame;

  ptr_datapath #(.OFF_W(OFF_W), .OFF_MAX(OFF_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .h1Strobe(h1Strobe),
    .h3Strobe(h3Strobe), .byteEn(byteEn), .cmd(cmd), .posFrame(posFrame),
    .flags(flags), .offset(offset), .stuffOut(stuffOut)
  );

  ptr_control #(.HOLD_FRAMES(HOLD_FRAMES), .ACCEPT_RUN(ACCEPT_RUN), .LOP_RUN(LOP_RUN)) u_ctl (
    .clk(clk), .rstN(rstN), .h1Strobe(h1Strobe), .h2Strobe(h2Strobe),
    .flags(flags), .cmd(cmd), .valid(offsetValid), .incPulse(incPulse),
    .decPulse(decPulse), .ndfPulse(ndfPulse), .concatInd(concatInd),
    .lop(lopOut), .negFrame(negFrame), .posFrame(posFrame)
  );

  assign h3Payload = h3Strobe && negFrame;

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    offsetValid |-> offset <= OFF_W'(OFF_MAX)); // R3

endmodule

// File: tb/tb_ptr_tracker.sv
module tb_ptr_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic h1Strobe = 1'b0, h2Strobe = 1'b0, h3Strobe = 1'b0, byteEn = 1'b0;
  logic [9:0] offset;
  logic offsetValid, incPulse, decPulse, ndfPulse, concatInd, lopOut, h3Payload, stuffOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int sOff, sValid, sInc, sDec, sNdf, sLop, sConcat, nH3, nStuff;

  always #10 clk = ~clk;

  ptr_tracker dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .h1Strobe(h1Strobe),
    .h2Strobe(h2Strobe), .h3Strobe(h3Strobe), .byteEn(byteEn),
    .offset(offset), .offsetValid(offsetValid), .incPulse(incPulse),
    .decPulse(decPulse), .ndfPulse(ndfPulse), .concatInd(concatInd),
    .lopOut(lopOut), .h3Payload(h3Payload), .stuffOut(stuffOut)
  );

  // {tag, word, expected offset, flags valid/inc/dec/ndf/lop}
  localparam logic [34:0] VEC [45] = '{
    {4'd3, 16'h6864, 10'd0,   5'b00000}, // R3 first of run
    {4'd3, 16'h6864, 10'd0,   5'b00000}, // R3
    {4'd3, 16'h6864, 10'd100, 5'b10000}, // R3 accepted
    {4'd3, 16'h6864, 10'd100, 5'b10000}, // R3
    {4'd4, 16'h6A4E, 10'd101, 5'b11000}, // R4 increment
    {4'd6, 16'h6A4F, 10'd101, 5'b10000}, // R6 blocked
    {4'd6, 16'h6865, 10'd101, 5'b10000}, // R6
    {4'd6, 16'h6865, 10'd101, 5'b10000}, // R6
    {4'd5, 16'h6930, 10'd100, 5'b10100}, // R5 decrement
    {4'd3, 16'h6864, 10'd100, 5'b10000}, // R3
    {4'd2, 16'h9B0E, 10'd782, 5'b10010}, // R2 new data
    {4'd3, 16'h6B0E, 10'd782, 5'b10000}, // R3
    {4'd4, 16'h69A4, 10'd0,   5'b11000}, // R4 wrap up
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd5, 16'h6955, 10'd782, 5'b10100}, // R5 wrap down
    {4'd3, 16'h6B0E, 10'd782, 5'b10000}, // R3
    {4'd3, 16'h6B0E, 10'd782, 5'b10000}, // R3
    {4'd3, 16'h6B0E, 10'd782, 5'b10000}, // R3
    {4'd4, 16'h68AE, 10'd0,   5'b11000}, // R4 three of five
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd3, 16'h6800, 10'd0,   5'b10000}, // R3
    {4'd1, 16'h680A, 10'd0,   5'b10000}, // R1 two votes only
    {4'd2, 16'h8832, 10'd50,  5'b10010}, // R2 code 1000
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7 invalid 1
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7
    {4'd7, 16'h0832, 10'd50,  5'b10000}, // R7 invalid 7
    {4'd7, 16'h0832, 10'd50,  5'b00001}, // R7 invalid 8: loss
    {4'd7, 16'h68C8, 10'd50,  5'b00001}, // R7
    {4'd7, 16'h68C8, 10'd50,  5'b00001}, // R7
    {4'd7, 16'h68C8, 10'd200, 5'b10000}, // R7 recovered
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8 ndf 1
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8
    {4'd8, 16'h992C, 10'd300, 5'b10010}, // R8 ndf 7
    {4'd8, 16'h992C, 10'd300, 5'b00011}  // R8 ndf 8: loss
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic sendPtr(input logic [15:0] w);
    @(negedge clk); dataIn = w[15:8]; h1Strobe = 1'b1;
    @(negedge clk); h1Strobe = 1'b0; dataIn = w[7:0]; h2Strobe = 1'b1;
    @(negedge clk); h2Strobe = 1'b0; dataIn = 8'h00;
    sOff = int'(offset); sValid = int'(offsetValid); sInc = int'(incPulse);
    sDec = int'(decPulse); sNdf = int'(ndfPulse); sLop = int'(lopOut);
    sConcat = int'(concatInd);
    nH3 = 0; nStuff = 0;
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      h3Strobe = 1'b1; byteEn = 1'b1; #1;
      if (h3Payload) nH3++;
      if (stuffOut) nStuff++;
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); h3Strobe = 1'b0; byteEn = 1'b1; #1;
      if (h3Payload) nH3++;
      if (stuffOut) nStuff++;
    end
    @(negedge clk); byteEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12", "offset", int'(offset), 0);
    chk("R12", "valid", int'(offsetValid), 0);
    chk("R12", "lop", int'(lopOut), 0);
    chk("R12", "concat", int'(concatInd), 0);
    chk("R12", "pulses", int'(incPulse) + int'(decPulse) + int'(ndfPulse), 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset();

    foreach (VEC[i]) begin
      string tag;
      tag = $sformatf("R%0d row %0d", int'(VEC[i][34:31]), i);
      sendPtr(VEC[i][30:15]);
      chk(tag, "offset", sOff, int'(VEC[i][14:5]));
      chk(tag, "valid", sValid, int'(VEC[i][4]));
      chk(tag, "inc", sInc, int'(VEC[i][3]));
      chk(tag, "dec", sDec, int'(VEC[i][2]));
      chk(tag, "ndf", sNdf, int'(VEC[i][1]));
      chk(tag, "lop", sLop, int'(VEC[i][0]));
      chk("R10", "h3 payload slots", nH3, 3 * int'(VEC[i][2]));
      chk("R11", "stuff slots", nStuff, 3 * int'(VEC[i][3]));
    end

    // R9: concatenation word, then a normal word clears it
    sendPtr(16'h9BFF);
    chk("R9", "concat set", sConcat, 1);
    chk("R9", "offset kept", sOff, 300);
    sendPtr(16'h6864);
    chk("R9", "concat clear", sConcat, 0);

    // R12 mid-run reset
    doReset();

    // R7: size field 2'b00 is invalid, never accepted
    sendPtr(16'h6064);
    sendPtr(16'h6064);
    sendPtr(16'h6064);
    chk("R7", "bad size not accepted", sValid, 0);
    chk("R7", "bad size offset", sOff, 0);

    // R3 then R1: decrement votes at even bits, majority of 3
    sendPtr(16'h6864); sendPtr(16'h6864); sendPtr(16'h6864);
    chk("R3", "accept after reset", sOff, 100);
    sendPtr(16'h6800 | (16'd100 ^ 16'h0054));
    chk("R1", "three even bits give dec", sDec, 1);
    chk("R5", "dec value", sOff, 99);
    chk("R10", "h3 payload on dec", nH3, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule